// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block is the write path from a fast bus clock into registers that are kept in a slow, always-on clock domain. A bus write to any register except the interrupt-enable register is captured into holding registers. It is announced to the slow side with a request toggle and applied there as a single-cycle write strobe. An acknowledge toggle then returns to the bus side. While a write is in flight the block reports itself busy. When the acknowledge comes back it raises a write-complete flag. A write that arrives while busy is refused and raises a write-error flag.

The interrupt-enable register lives in the bus domain. It is written at once, never goes through the handshake and never raises completion. The status register is read from the bus side. A read of it clears the write-complete flag. The write-error flag is cleared by writing a one to its status bit, and that write travels through the handshake like any other. A single interrupt output combines the three flags with their enables.

Top module: `lpw_write_sync`

## Requirements
- R1: Every accepted write to an address other than 0x18 produces exactly one `lp_we` pulse, one slow-clock cycle long, carrying the written address on `lp_addr` and the written data on `lp_data`.
- R2: From the bus edge that accepts a write until completion, status (offset 0x14) reads busy at bit 10 = 1 and ready-for-next at bit 9 = 0, and the captured address and data stay unchanged. At all other times bit 10 = 0 and bit 9 = 1.
- R3: When the acknowledge returns, busy falls and write-complete (status bit 8) rises on the same bus edge. If a status read falls in that same cycle, the flag is still set.
- R4: A write to the interrupt-enable register (offset 0x18) updates it on the next bus edge. Only bits 9, 8 and 7 are kept and read back; the other bits read 0. Such a write never sets busy or write-complete, never produces an `lp_we` pulse, and is accepted while busy without raising write-error.
- R5: A status read returns the current write-complete value and clears the flag on the following edge.
- R6: A write to any address other than 0x18 while busy is dropped. It produces no `lp_we` pulse, leaves the captured data alone and sets write-error (status bit 7).
- R7: A status write is synchronized like any other write. If its bit 7 is 1, write-error clears on its completion edge. If bit 7 is 0, write-error is unchanged.
- R8: `irq` is high when (ready-for-next and enable bit 9) or (write-complete and enable bit 8) or (write-error and enable bit 7).
- R9: After reset, status reads busy 0, ready-for-next 1, write-complete 0 and write-error 0, the interrupt-enable register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| clk_lp | input | 1 | Slow always-on clock |
| rst_lp_n | input | 1 | Asynchronous active-low reset, slow domain |
| wr_valid | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write byte offset |
| wr_data | input | DW | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | AW | Bus read byte offset |
| rd_data | output | DW | Read data for `rd_addr` (status or interrupt enable; 0 otherwise) |
| irq | output | 1 | Combined flag-and-enable interrupt |
| lp_we | output | 1 | Slow-domain write strobe |
| lp_addr | output | AW | Slow-domain write offset |
| lp_data | output | DW | Slow-domain write data |

## Verification
The main function is driven with plain writes to several offsets, using all-zero, all-one and mixed data. This shows whether address and data cross intact, and exactly once, rather than being stuck or repeated. A second write issued one cycle after the first tells a correct drop apart from an overwrite of the held data. An interrupt-enable write placed inside a busy window shows that it bypasses the handshake. Status writes with bit 7 at 0 and then at 1 separate the error-clear action from the ordinary completion path. Polling status until idle, and watching `irq` with reads held off, shows that write-complete is set together with the busy fall and is cleared only by a read.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  // byte offsets decoded by software
  localparam logic [7:0] OFF_STATUS = 8'h14;
  localparam logic [7:0] OFF_IE     = 8'h18;

  // status bit positions
  localparam int ST_BUSY = 10;
  localparam int ST_NEXT = 9;
  localparam int ST_DONE = 8;
  localparam int ST_ERR  = 7;

  // interrupt-enable bit positions (same places as the flags they gate)
  localparam int IE_NEXT = 9;
  localparam int IE_DONE = 8;
  localparam int IE_ERR  = 7;

  typedef struct packed {
    logic en_next;
    logic en_done;
    logic en_err;
  } ie_bits_t;
endpackage

// File: rtl/lpw_bit_sync.sv
// Multi-flop synchronizer; with d tied high it serves as a reset synchronizer.
module lpw_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpw_bus_side.sv
module lpw_bus_side
  import lpw_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          ack_sync,
  output logic          req_tgl,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          ack_edge
);
  localparam logic [AW-1:0] A_STATUS = AW'(OFF_STATUS);
  localparam logic [AW-1:0] A_IE     = AW'(OFF_IE);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          req_q, req_d;
  logic          ack_seen_q;
  logic          clr_pend_q, clr_pend_d;
  logic [AW-1:0] haddr_q;
  logic [DW-1:0] hdata_q;
  ie_bits_t      ie_q, ie_d;

  logic is_ie, accept, drop, st_rd, ie_we;

  always_comb begin
    is_ie    = (wr_addr == A_IE);
    ie_we    = wr_valid && is_ie;
    accept   = wr_valid && !is_ie && !busy_q;
    drop     = wr_valid && !is_ie && busy_q;
    st_rd    = rd_en && (rd_addr == A_STATUS);
    ack_edge = ack_sync ^ ack_seen_q;

    busy_d = busy_q;
    if (accept)        busy_d = 1'b1;
    else if (ack_edge) busy_d = 1'b0;

    done_d = done_q;
    if (ack_edge)   done_d = 1'b1;   // set wins over read-clear
    else if (st_rd) done_d = 1'b0;

    err_d = err_q;
    if (drop)                         err_d = 1'b1;
    else if (ack_edge && clr_pend_q)  err_d = 1'b0;

    req_d      = accept ? ~req_q : req_q;
    clr_pend_d = accept ? ((wr_addr == A_STATUS) && wr_data[ST_ERR]) : clr_pend_q;

    ie_d = ie_q;
    if (ie_we) ie_d = '{en_next: wr_data[IE_NEXT], en_done: wr_data[IE_DONE],
                        en_err: wr_data[IE_ERR]};
  end

  // flag and handshake registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      clr_pend_q <= 1'b0;
      ie_q       <= '0;
    end else begin
      busy_q     <= busy_d;
      done_q     <= done_d;
      err_q      <= err_d;
      req_q      <= req_d;
      ack_seen_q <= ack_sync;
      clr_pend_q <= clr_pend_d;
      ie_q       <= ie_d;
    end
  end

  // holding registers, enabled only on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q <= '0;
      hdata_q <= '0;
    end else if (accept) begin
      haddr_q <= wr_addr;
      hdata_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_STATUS) begin
      rd_data[ST_BUSY] = busy_q;
      rd_data[ST_NEXT] = ~busy_q;
      rd_data[ST_DONE] = done_q;
      rd_data[ST_ERR]  = err_q;
    end else if (rd_addr == A_IE) begin
      rd_data[IE_NEXT] = ie_q.en_next;
      rd_data[IE_DONE] = ie_q.en_done;
      rd_data[IE_ERR]  = ie_q.en_err;
    end
  end

  assign irq = (~busy_q & ie_q.en_next) | (done_q & ie_q.en_done) |
               (err_q & ie_q.en_err);

  assign req_tgl   = req_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/lpw_lp_side.sv
module lpw_lp_side #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_sync,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  output logic          lp_we,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data,
  output logic          ack_tgl
);
  logic          req_seen_q;
  logic          ack_q, ack_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          req_edge;

  always_comb begin
    req_edge = req_sync ^ req_seen_q;
    ack_d    = req_edge ? ~ack_q : ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      we_q       <= 1'b0;
    end else begin
      req_seen_q <= req_sync;
      ack_q      <= ack_d;
      we_q       <= req_edge;
    end
  end

  // hold data are stable across the whole request, sampled on its edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (req_edge) begin
      addr_q <= hold_addr;
      data_q <= hold_data;
    end
  end

  assign lp_we   = we_q;
  assign lp_addr = addr_q;
  assign lp_data = data_q;
  assign ack_tgl = ack_q;
endmodule

// File: rtl/lpw_write_sync.sv
module lpw_write_sync #(
  parameter int AW          = 5,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_bus,
  input  logic          rst_bus_n,
  input  logic          clk_lp,
  input  logic          rst_lp_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          lp_we,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data
);
  logic          bus_rst_n, lp_rst_n;
  logic          req_tgl, req_sync, ack_tgl, ack_sync;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic          flag_busy, flag_done, flag_err, ack_edge;

  lpw_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_bus (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(1'b1), .q(bus_rst_n));

  lpw_bit_sync #(.STAGES(SYNC_STAGES)) u_rst_lp (
    .clk(clk_lp), .rst_n(rst_lp_n), .d(1'b1), .q(lp_rst_n));

  lpw_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_lp), .rst_n(lp_rst_n), .d(req_tgl), .q(req_sync));

  lpw_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_bus), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_sync));

  lpw_bus_side #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk_bus), .rst_n(bus_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .ack_sync(ack_sync),
    .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
    .rd_data(rd_data), .irq(irq),
    .busy(flag_busy), .done(flag_done), .err(flag_err), .ack_edge(ack_edge));

  lpw_lp_side #(.AW(AW), .DW(DW)) u_lp (
    .clk(clk_lp), .rst_n(lp_rst_n), .req_sync(req_sync),
    .hold_addr(hold_addr), .hold_data(hold_data),
    .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data), .ack_tgl(ack_tgl));
endmodule

// File: rtl/lpw_write_sync_chk.sv
module lpw_write_sync_chk
  import lpw_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk_bus,
  input logic          clk_lp,
  input logic          rst_b,
  input logic          rst_l,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          ack_edge,
  input logic [DW-1:0] hold_data,
  input logic          lp_we
);
  localparam logic [AW-1:0] A_STATUS = AW'(OFF_STATUS);
  localparam logic [AW-1:0] A_IE     = AW'(OFF_IE);

  AST_BUSY_FROM_CAPTURE: assert property (@(posedge clk_bus) disable iff (!rst_b)
    $rose(busy) |-> $past(wr_valid && (wr_addr != A_IE))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_bus) disable iff (!rst_b)
    (busy && $past(busy)) |-> $stable(hold_data)); // R2

  AST_DONE_WITH_IDLE: assert property (@(posedge clk_bus) disable iff (!rst_b)
    $rose(done) |-> $fell(busy)); // R3

  AST_SET_BEATS_READ: assert property (@(posedge clk_bus) disable iff (!rst_b)
    (ack_edge && rd_en && (rd_addr == A_STATUS)) |=> done); // R3

  AST_IE_NO_HANDSHAKE: assert property (@(posedge clk_bus) disable iff (!rst_b)
    (wr_valid && (wr_addr == A_IE) && !busy && !ack_edge) |=> !busy); // R4

  AST_READ_CLEARS: assert property (@(posedge clk_bus) disable iff (!rst_b)
    (rd_en && (rd_addr == A_STATUS) && !ack_edge) |=> !done); // R5

  AST_DROP_SETS_ERR: assert property (@(posedge clk_bus) disable iff (!rst_b)
    (wr_valid && (wr_addr != A_IE) && busy) |=> err); // R6

  AST_APPLY_ONE_CYCLE: assert property (@(posedge clk_lp) disable iff (!rst_l)
    lp_we |=> !lp_we); // R1
endmodule

bind lpw_write_sync lpw_write_sync_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_bus(clk_bus), .clk_lp(clk_lp), .rst_b(bus_rst_n), .rst_l(lp_rst_n),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
  .busy(flag_busy), .done(flag_done), .err(flag_err), .ack_edge(ack_edge),
  .hold_data(hold_data), .lp_we(lp_we));

// File: tb/test_lpw_write_sync.sv
module test_lpw_write_sync;
  localparam int CLK_NS = 10;
  localparam int LP_NS  = 74;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_STATUS = 5'h14;
  localparam logic [AW-1:0] A_IE     = 5'h18;

  logic          clk_bus, clk_lp, rst_bus_n, rst_lp_n;
  logic          wr_valid, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data, lp_data;
  logic [AW-1:0] lp_addr;
  logic          irq, lp_we;

  int n_chk, n_err, n_apply;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  logic finished;

  lpw_write_sync #(.AW(AW), .DW(DW)) i_lpw_write_sync (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_lp(clk_lp), .rst_lp_n(rst_lp_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .lp_we(lp_we), .lp_addr(lp_addr), .lp_data(lp_data));

  initial begin clk_bus = 0; forever #(CLK_NS/2) clk_bus = ~clk_bus; end
  initial begin clk_lp = 0; forever #(LP_NS/2) clk_lp = ~clk_lp; end

  // slow-side monitor, sampled away from the active edge
  initial begin n_apply = 0; last_addr = '0; last_data = '0; end
  always @(negedge clk_lp) begin
    if (lp_we) begin
      n_apply++;
      last_addr = lp_addr;
      last_data = lp_data;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_bus);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_bus);
    wr_valid = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk_bus);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk_bus);
    rd_en = 1'b0;
  endtask

  // status bits 10..7 = busy, next, done, err
  task automatic wait_idle(output logic [3:0] st);
    logic [DW-1:0] r;
    st = 4'b1000;
    for (int i = 0; i < 400; i++) begin
      bus_read(A_STATUS, r);
      st = r[10:7];
      if (!r[10]) break;
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    bus_read(A_STATUS, r);
    check(r == 32'h200, "R9 status after reset", r, 32'h200);
    bus_read(A_IE, r);
    check(r == 0, "R9 ie after reset", r, 0);
    check(irq == 1'b0, "R9 irq after reset", {31'b0, irq}, 0);
    check(n_apply == 0, "R9 no apply after reset", n_apply, 0);
  endtask

  task automatic t_basic(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    logic [3:0] st;
    int n0 = n_apply;
    bus_write(a, d);
    bus_read(A_STATUS, r);
    check(r[10:9] == 2'b10, "R2 busy and not next in flight", r[10:9], 2'b10);
    wait_idle(st);
    check(st == 4'b0110, "R3 done rises with busy fall", st, 4'b0110);
    repeat (3) @(negedge clk_lp);
    check(n_apply == n0 + 1, "R1 single apply", n_apply, n0 + 1);
    check(last_addr == a && last_data == d, "R1 applied address and data",
          last_data, d);
    bus_read(A_STATUS, r);
    check(r[8] == 1'b0, "R5 done cleared by prior read", r[8], 0);
  endtask

  task automatic t_ie();
    logic [DW-1:0] r;
    logic [3:0] st;
    int n0 = n_apply;
    bus_write(A_IE, 32'hFFFF_FFFF);
    bus_read(A_IE, r);
    check(r == 32'h380, "R4 ie keeps bits 9..7", r, 32'h380);
    repeat (8) @(negedge clk_lp);
    bus_read(A_STATUS, r);
    check(r[10:7] == 4'b0100, "R4 ie write no busy no done", r[10:7], 4'b0100);
    check(n_apply == n0, "R4 ie write not applied", n_apply, n0);
    // ie write inside a busy window
    bus_write(5'h04, 32'h1234_5678);
    bus_write(A_IE, 32'h0);
    bus_read(A_STATUS, r);
    check(r[10] == 1'b1 && r[7] == 1'b0, "R4 ie write while busy accepted",
          r[10:7], 4'b1000);
    bus_read(A_IE, r);
    check(r == 0, "R4 ie updated while busy", r, 0);
    wait_idle(st);
    repeat (3) @(negedge clk_lp);
    check(n_apply == n0 + 1 && last_data == 32'h1234_5678, "R4 only data write applied",
          n_apply, n0 + 1);
    bus_read(A_STATUS, r);
  endtask

  task automatic t_drop();
    logic [DW-1:0] r;
    logic [3:0] st;
    int n0 = n_apply;
    bus_write(5'h08, 32'hCAFE_0001);
    bus_write(5'h0C, 32'hDEAD_0002);
    bus_read(A_STATUS, r);
    check(r[7] == 1'b1, "R6 dropped write sets error", r[10:7], 4'b1001);
    wait_idle(st);
    repeat (10) @(negedge clk_lp);
    check(n_apply == n0 + 1, "R6 dropped write not applied", n_apply, n0 + 1);
    check(last_data == 32'hCAFE_0001 && last_addr == 5'h08, "R6 held data kept",
          last_data, 32'hCAFE_0001);
    bus_read(A_STATUS, r);
  endtask

  task automatic t_irq();
    logic [DW-1:0] r;
    logic seen;
    bus_write(A_IE, 32'h080);
    check(irq == 1'b1, "R8 irq from error", irq, 1);
    bus_write(A_IE, 32'h000);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    bus_write(A_IE, 32'h200);
    check(irq == 1'b1, "R8 irq from next while idle", irq, 1);
    bus_write(A_IE, 32'h100);
    check(irq == 1'b0, "R8 irq done enable with done low", irq, 0);
    bus_write(5'h00, 32'h0F0F_F0F0);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_bus);
      if (irq) begin seen = 1'b1; break; end
    end
    check(seen, "R8 irq from done", seen, 1);
    bus_read(A_STATUS, r);
    @(negedge clk_bus);
    check(irq == 1'b0, "R5 read clears done and irq", irq, 0);
    bus_write(A_IE, 32'h000);
  endtask

  task automatic t_clear();
    logic [3:0] st;
    int n0 = n_apply;
    bus_write(A_STATUS, 32'h0000_0000);
    wait_idle(st);
    check(st[0] == 1'b1, "R7 bit7 zero keeps error", st, 4'b0111);
    repeat (3) @(negedge clk_lp);
    check(n_apply == n0 + 1 && last_addr == A_STATUS, "R7 status write applied",
          n_apply, n0 + 1);
    bus_write(A_STATUS, 32'h0000_0080);
    wait_idle(st);
    check(st == 4'b0110, "R7 error cleared at completion", st, 4'b0110);
    repeat (3) @(negedge clk_lp);
    check(n_apply == n0 + 2, "R7 clear write applied", n_apply, n0 + 2);
  endtask

  initial begin
    n_chk = 0; n_err = 0; finished = 1'b0;
    wr_valid = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    rst_bus_n = 0; rst_lp_n = 0;
    #(LP_NS*3);
    @(negedge clk_bus);
    rst_bus_n = 1; rst_lp_n = 1;
    #(LP_NS*4);
    t_reset();
    t_basic(5'h00, 32'hA5A5_0F0F);
    t_basic(5'h0C, 32'hFFFF_FFFF);
    t_basic(5'h10, 32'h0000_0000);
    t_ie();
    t_drop();
    t_irq();
    t_clear();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS*150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule